// File: doc/BRIEF.md
# Dual-Timer Compare Output Modulator

This block is the output stage that places the compare outputs of two independent timers on one shared pin. Each timer has a compare-output unit. On a compare-match strobe, the unit sets, clears or toggles its own output register, as selected by that channel's 2-bit mode field. A channel whose mode field is nonzero takes the pin away from the port data bit. The timer counters that produce the match strobes are outside the block.

When both channels are enabled at the same time, a modulator turns on by itself, and no extra enable bit is involved. The modulator merges the two waveforms, so that one channel acts as a carrier for the other. The port data bit then chooses how they are combined: 0 gives the AND of the two compare outputs and 1 gives the OR. The pin is a register, so it follows its selected source one system clock later.

Top module: `ocm_top`

## Requirements
- R1: After reset, both compare output registers hold 0 and the pin output holds 0.
- R2: With mode 01, a match strobe inverts the channel's compare output register at the next rising clock edge.
- R3: With mode 10, a match strobe sets the channel's compare output register to 0 at the next rising clock edge.
- R4: With mode 11, a match strobe sets the channel's compare output register to 1 at the next rising clock edge.
- R5: With mode 00, a match strobe has no effect, and the channel's compare output register keeps its value.
- R6: When both mode fields are 00, the pin takes the port data bit one clock later.
- R7: When exactly one mode field is nonzero, the pin takes that channel's compare output register one clock later, whatever the port data bit is.
- R8: When both mode fields are nonzero and the port data bit is 0, the pin takes the AND of the two compare output registers one clock later.
- R9: When both mode fields are nonzero and the port data bit is 1, the pin takes the OR of the two compare output registers one clock later.
- R10: A change of a compare output register appears on the pin one clock after the register changes, never in the same cycle.
- R11: Without a match strobe, a compare output register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| matchA | input | 1 | Compare-match strobe of the 16-bit timer channel (A) |
| matchB | input | 1 | Compare-match strobe of the 8-bit timer channel (B) |
| modeA | input | 2 | Compare mode of channel A: 00 off, 01 toggle, 10 clear, 11 set |
| modeB | input | 2 | Compare mode of channel B, with the same encoding |
| portData | input | 1 | Port data bit; in modulator mode it selects AND (0) or OR (1) |
| pinOut | output | 1 | Registered value of the shared pin |

## Verification
Assertions check on every cycle how each match strobe acts on its compare register in every mode. They also check that the register holds when there is no strobe, and that the pin takes the source picked by the mode fields and the port data bit one cycle later. The compare registers are internal, so only the bench's scenarios can show them at the pin. The scenarios show the reset value, a value kept through a disabled-mode match and then revealed by enabling the channel, and the exact cycle in which a compare change reaches the pin. They also show the AND and OR results for every mix of compare values.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

  localparam int CH_NUM = 2;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 2'b00,
    MODE_TOGGLE = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_SET    = 2'b11
  } cmpMode_e;

  typedef enum logic [2:0] {
    SEL_PORT = 3'd0,
    SEL_A    = 3'd1,
    SEL_B    = 3'd2,
    SEL_AND  = 3'd3,
    SEL_OR   = 3'd4
  } pinSel_e;

  typedef struct packed {
    logic [CH_NUM-1:0] doToggle;
    logic [CH_NUM-1:0] doClear;
    logic [CH_NUM-1:0] doSet;
    pinSel_e           pinSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/ocm_ctrl.sv
module ocm_ctrl
  import ocm_pkg::*;
(
  input  logic [CH_NUM-1:0]             match,
  input  logic [CH_NUM-1:0][MODE_W-1:0] mode,
  input  logic                          portData,
  output ctrlStrobes_t                  strobes
);

  logic [CH_NUM-1:0] chEnabled;

  // Per-channel action decode
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_decode
    cmpMode_e chMode;
    assign chMode = cmpMode_e'(mode[ch]);
    assign chEnabled[ch] = (chMode != MODE_OFF);

    always_comb begin
      strobes.doToggle[ch] = 1'b0;
      strobes.doClear[ch]  = 1'b0;
      strobes.doSet[ch]    = 1'b0;
      if (match[ch]) begin
        unique case (chMode)
          MODE_TOGGLE: strobes.doToggle[ch] = 1'b1;
          MODE_CLEAR:  strobes.doClear[ch]  = 1'b1;
          MODE_SET:    strobes.doSet[ch]    = 1'b1;
          default:     ;
        endcase
      end
    end
  end

  // Pin source selection: override and automatic modulator
  always_comb begin
    unique case (chEnabled)
      2'b00:   strobes.pinSel = SEL_PORT;
      2'b01:   strobes.pinSel = SEL_A;
      2'b10:   strobes.pinSel = SEL_B;
      default: strobes.pinSel = portData ? SEL_OR : SEL_AND;
    endcase
  end

endmodule

// File: rtl/ocm_datapath.sv
module ocm_datapath
  import ocm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              portData,
  output logic [CH_NUM-1:0] cmpQ,
  output logic              pinQ
);

  // Compare output registers
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_cmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpQ[ch] <= 1'b0;
      end else if (strobes.doToggle[ch]) begin
        cmpQ[ch] <= ~cmpQ[ch];
      end else if (strobes.doClear[ch]) begin
        cmpQ[ch] <= 1'b0;
      end else if (strobes.doSet[ch]) begin
        cmpQ[ch] <= 1'b1;
      end
    end
  end

  // Pin mux and output register
  logic pinNext;

  always_comb begin
    unique case (strobes.pinSel)
      SEL_A:   pinNext = cmpQ[0];
      SEL_B:   pinNext = cmpQ[1];
      SEL_AND: pinNext = &cmpQ;
      SEL_OR:  pinNext = |cmpQ;
      default: pinNext = portData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinQ <= 1'b0;
    else       pinQ <= pinNext;
  end

endmodule

// File: rtl/ocm_top.sv
module ocm_top
  import ocm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              matchA,
  input  logic              matchB,
  input  logic [MODE_W-1:0] modeA,
  input  logic [MODE_W-1:0] modeB,
  input  logic              portData,
  output logic              pinOut
);

  logic [CH_NUM-1:0]             matchVec;
  logic [CH_NUM-1:0][MODE_W-1:0] modeVec;
  logic [CH_NUM-1:0]             cmpQ;
  ctrlStrobes_t                  strobes;

  assign matchVec = {matchB, matchA};
  assign modeVec  = {modeB, modeA};

  ocm_ctrl i_ctrl (
    .match    (matchVec),
    .mode     (modeVec),
    .portData (portData),
    .strobes  (strobes)
  );

  ocm_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .portData (portData),
    .cmpQ     (cmpQ),
    .pinQ     (pinOut)
  );

  // Per-channel compare behaviour
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chk
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
      (matchVec[ch] && modeVec[ch] == MODE_TOGGLE) |=> (cmpQ[ch] != $past(cmpQ[ch]))); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (matchVec[ch] && modeVec[ch] == MODE_CLEAR) |=> !cmpQ[ch]); // R3
    AST_SET_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (matchVec[ch] && modeVec[ch] == MODE_SET) |=> cmpQ[ch]); // R4
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[ch] == MODE_OFF) |=> $stable(cmpQ[ch])); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !matchVec[ch] |=> $stable(cmpQ[ch])); // R11
  end

  // Pin source behaviour
  AST_PORT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (modeA == MODE_OFF && modeB == MODE_OFF) |=> (pinOut == $past(portData))); // R6
  AST_SINGLE_A: assert property (@(posedge clk) disable iff (!rstN)
    (modeA != MODE_OFF && modeB == MODE_OFF) |=> (pinOut == $past(cmpQ[0]))); // R7
  AST_SINGLE_B: assert property (@(posedge clk) disable iff (!rstN)
    (modeA == MODE_OFF && modeB != MODE_OFF) |=> (pinOut == $past(cmpQ[1]))); // R7
  AST_MOD_AND: assert property (@(posedge clk) disable iff (!rstN)
    (modeA != MODE_OFF && modeB != MODE_OFF && !portData)
      |=> (pinOut == $past(cmpQ[0] & cmpQ[1]))); // R8
  AST_MOD_OR: assert property (@(posedge clk) disable iff (!rstN)
    (modeA != MODE_OFF && modeB != MODE_OFF && portData)
      |=> (pinOut == $past(cmpQ[0] | cmpQ[1]))); // R9

  always_ff @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_VAL: assert (cmpQ == '0 && !pinOut); // R1
    end
  end

endmodule

// File: tb/test_ocm_top.sv
`timescale 1ns/100ps
module test_ocm_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       matchA = 1'b0;
  logic       matchB = 1'b0;
  logic [1:0] modeA = 2'b00;
  logic [1:0] modeB = 2'b00;
  logic       portData = 1'b0;
  logic       pinOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocm_top i_ocm_top (
    .clk(clk), .rstN(rstN), .matchA(matchA), .matchB(matchB),
    .modeA(modeA), .modeB(modeB), .portData(portData), .pinOut(pinOut)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pinOut=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse a match on one channel for one cycle (called at a negedge)
  task automatic pulse(input bit chB);
    if (chB) matchB = 1'b1; else matchA = 1'b1;
    cyc(1);
    matchA = 1'b0;
    matchB = 1'b0;
  endtask

  // Force a compare register to a value using set/clear, channel alone enabled
  task automatic load(input bit chB, input bit val);
    if (chB) begin modeA = 2'b00; modeB = val ? 2'b11 : 2'b10; end
    else     begin modeB = 2'b00; modeA = val ? 2'b11 : 2'b10; end
    pulse(chB);
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(1);
    check(pinOut, 1'b0, "R1 pin in reset");
    rstN = 1'b1;
    cyc(2);
    check(pinOut, 1'b0, "R1 pin after reset");
    portData = 1'b1;
    modeA = 2'b01;
    cyc(2);
    check(pinOut, 1'b0, "R1 channel A reset value");
    modeA = 2'b00; modeB = 2'b01;
    cyc(2);
    check(pinOut, 1'b0, "R1 channel B reset value");
    modeB = 2'b00; portData = 1'b0;
    cyc(1);
  endtask

  task automatic t_port();
    portData = 1'b1;
    cyc(1);
    check(pinOut, 1'b1, "R6 port data 1");
    portData = 1'b0;
    cyc(1);
    check(pinOut, 1'b0, "R6 port data 0");
  endtask

  task automatic t_setClearLatency();
    portData = 1'b1;
    modeA = 2'b11;
    cyc(1);
    check(pinOut, 1'b0, "R7 pin follows A, not port");
    matchA = 1'b1;
    cyc(1);
    matchA = 1'b0;
    check(pinOut, 1'b0, "R10 pin unchanged in update cycle");
    cyc(1);
    check(pinOut, 1'b1, "R4 set on match");
    cyc(3);
    check(pinOut, 1'b1, "R11 hold without match");
    modeA = 2'b10;
    pulse(1'b0);
    cyc(1);
    check(pinOut, 1'b0, "R3 clear on match");
    portData = 1'b0;
  endtask

  task automatic t_toggle();
    modeA = 2'b00;
    modeB = 2'b01;
    pulse(1'b1);
    cyc(1);
    check(pinOut, 1'b1, "R2 toggle B 0->1");
    matchB = 1'b1;
    cyc(2);
    matchB = 1'b0;
    cyc(1);
    check(pinOut, 1'b1, "R2 two toggles return to 1");
    pulse(1'b1);
    cyc(1);
    check(pinOut, 1'b0, "R2 toggle B 1->0");
  endtask

  task automatic t_offIgnored();
    load(1'b0, 1'b1);
    modeA = 2'b00; portData = 1'b0;
    pulse(1'b0);
    cyc(1);
    check(pinOut, 1'b0, "R6 port while A off");
    modeA = 2'b01;
    cyc(1);
    check(pinOut, 1'b1, "R5 off-mode match left A at 1");
    modeA = 2'b00;
  endtask

  task automatic t_modulator();
    for (int combo = 0; combo < 4; combo++) begin
      bit a = combo[0];
      bit b = combo[1];
      load(1'b0, a);
      load(1'b1, b);
      modeA = 2'b01; modeB = 2'b01;
      portData = 1'b0;
      cyc(1);
      check(pinOut, a & b, "R8 modulator AND");
      portData = 1'b1;
      cyc(1);
      check(pinOut, a | b, "R9 modulator OR");
    end
    modeA = 2'b00; modeB = 2'b00; portData = 1'b0;
    cyc(1);
  endtask

  initial begin
    t_reset();
    t_port();
    t_setClearLatency();
    t_toggle();
    t_offIgnored();
    t_modulator();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule